// File: doc/BRIEF.md
# Sequential Booth Multiplier (radix 2)

This block multiplies two signed two's-complement integers of `WIDTH` bits and returns their full `2*WIDTH`-bit product. It is built for area, not speed. It loads the operands in one clock and then spends one clock per multiplier bit on a single adder. In each of those clocks, the lowest multiplier bit and the bit shifted out just before it choose one of three actions: add the multiplicand into the running upper half, subtract it, or leave the upper half alone. The upper half, the multiplier register and the saved bit then move one place right as a single sign-preserving register.

A client raises `start` for one clock while `busy` is low. `busy` is high during the iterations. When the last iteration has been written, `done` pulses for exactly one clock and `product` holds the result. The result stays on the port until the next accepted `start`. A `start` raised while `busy` is high has no effect.

The running upper half carries one guard bit above `WIDTH`. This lets the most negative multiplicand be negated without wrapping. The low `2*WIDTH` bits of the final register pair form the product.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is low captures both operands, and `busy` is 1 from the next clock.
- R3: `product` equals the signed product of the captured operands, as a `2*WIDTH`-bit two's-complement value. Example: with WIDTH 4, 4'b1011 (-5) times 4'b1001 (-7) gives 8'b0010_0011 (35).
- R4: `done` goes high exactly `WIDTH` clocks after the clock in which `busy` rose. It stays high for one clock only, and `busy` is 0 whenever `done` is 1.
- R5: A `start` raised while `busy` is 1 is ignored. The result and the completion timing belong to the operands captured first.
- R6: Operands at the most negative value give the exact product, including the most negative value times itself (with WIDTH 8, -128 times -128 gives 16'h4000).
- R7: While `busy` is 0 and no `start` is accepted, `product` does not change.
- R8: After every iteration, the running upper half fits in `WIDTH` signed bits (its guard bit equals its sign bit).
- R9: The recoding uses the multiplier's lowest bit and the previously shifted-out bit, taking that bit as 0 on the first iteration. Pair (1,0) subtracts the multiplicand, pair (0,1) adds it, and pairs (0,0) and (1,1) leave the upper half unchanged before the arithmetic right shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted only while idle |
| multiplicand_i | input | WIDTH | Signed multiplicand |
| multiplier_i | input | WIDTH | Signed multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-clock pulse when the product is ready |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
All 256 operand pairs are run at width 4, so every pattern of runs of ones and zeros in the multiplier is exercised. A recoder that swapped the add and subtract cases, or that lost the saved bit between iterations, would give wrong products on almost every odd multiplier. The most negative multiplicand is checked by itself and paired with extreme multipliers. A datapath without the guard bit wraps when it negates this value and returns a product with the wrong sign. Exact-cycle checks on `busy` and `done` catch an off-by-one iteration count, which shows up as a product scaled by a power of two. A `start` injected in the middle of a run catches a controller that reloads while busy, since that design would return the second pair's product or finish late.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    BOOTH_SKIP = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } booth_op_e;

  // Radix-2 recoding of (current multiplier LSB, previously shifted-out bit).
  function automatic booth_op_e booth_decode(input logic cur_bit, input logic prev_bit);
    case ({cur_bit, prev_bit})
      2'b10:   return BOOTH_SUB;
      2'b01:   return BOOTH_ADD;
      default: return BOOTH_SKIP;
    endcase
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op,
  output logic      add_ev,
  output logic      sub_ev
);

  always_comb begin
    op     = booth_decode(cur_bit, prev_bit);
    add_ev = (op == BOOTH_ADD);
    sub_ev = (op == BOOTH_SUB);
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 9
) (
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] mcand,
  input  booth_op_e    op,
  output logic [W-1:0] sum
);

  logic [W-1:0] operand;
  logic         carry_in;

  // Subtraction is performed as addition of the one's complement plus a carry.
  always_comb begin
    case (op)
      BOOTH_ADD: begin operand = mcand;  carry_in = 1'b0; end
      BOOTH_SUB: begin operand = ~mcand; carry_in = 1'b1; end
      default:   begin operand = '0;     carry_in = 1'b0; end
    endcase
    sum = acc_in + operand + W'(carry_in);
  end

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;
  logic          last_w;

  assign load   = start && !busy_q;
  assign step   = busy_q;
  assign last_w = busy_q && (cnt_q == CW'(1));
  assign busy   = busy_q;
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        cnt_q  <= CW'(N);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CW'(1);
        if (last_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && cnt_q == CW'(N))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q > CW'(1)) |=> (busy && cnt_q == $past(cnt_q) - CW'(1))); // R5

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand_i,
  input  logic [WIDTH-1:0]   multiplier_i,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  localparam int EW = WIDTH + 1; // accumulator with one guard bit

  logic [EW-1:0]    acc_q;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] mplr_q;
  logic             prev_q;

  logic      load_w;
  logic      step_w;
  booth_op_e op_w;
  logic      add_ev_w;
  logic      sub_ev_w;
  logic [EW-1:0] mcand_ext_w;
  logic [EW-1:0] sum_w;

  booth_seq_ctrl #(.N(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load_w),
    .step  (step_w),
    .busy  (busy),
    .done  (done)
  );

  booth_recode u_recode (
    .cur_bit  (mplr_q[0]),
    .prev_bit (prev_q),
    .op       (op_w),
    .add_ev   (add_ev_w),
    .sub_ev   (sub_ev_w)
  );

  assign mcand_ext_w = {mcand_q[WIDTH-1], mcand_q};

  booth_addsub #(.W(EW)) u_addsub (
    .acc_in (acc_q),
    .mcand  (mcand_ext_w),
    .op     (op_w),
    .sum    (sum_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mplr_q  <= '0;
      prev_q  <= 1'b0;
    end else if (load_w) begin
      acc_q   <= '0;
      mcand_q <= multiplicand_i;
      mplr_q  <= multiplier_i;
      prev_q  <= 1'b0;
    end else if (step_w) begin
      // Arithmetic right shift of {sum, multiplier, prev} as one register.
      acc_q  <= {sum_w[EW-1], sum_w[EW-1:1]};
      mplr_q <= {sum_w[0], mplr_q[WIDTH-1:1]};
      prev_q <= mplr_q[0];
    end
  end

  assign product = {acc_q[WIDTH-1:0], mplr_q};

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> (acc_q[EW-1] == acc_q[EW-2])); // R8
  AST_SKIP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && !add_ev_w && !sub_ev_w) |=> (acc_q == {$past(acc_q[EW-1]), $past(acc_q[EW-1:1])})); // R9
  AST_PREV_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> (prev_q == $past(mplr_q[0]))); // R9
  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load_w) |=> $stable(product)); // R7
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |-> (product == '0)); // R1

endmodule

// File: tb/booth_seq_mul_bench.sv
`timescale 1ns/1ps
module booth_seq_mul_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  // width 8 instance
  logic        s8 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        busy8, done8;
  logic [15:0] p8;

  // width 4 instance
  logic        s4 = 1'b0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        busy4, done4;
  logic [7:0]  p4;

  booth_seq_mul #(.WIDTH(8)) u_booth_seq_mul (
    .clk(clk), .rst_n(rst_n), .start(s8), .multiplicand_i(a8), .multiplier_i(b8),
    .busy(busy8), .done(done8), .product(p8));

  booth_seq_mul #(.WIDTH(4)) u_booth_seq_mul_n4 (
    .clk(clk), .rst_n(rst_n), .start(s4), .multiplicand_i(a4), .multiplier_i(b4),
    .busy(busy4), .done(done4), .product(p4));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b);
    int av = {{24{a[7]}}, a};
    int bv = {{24{b[7]}}, b};
    return 16'(av * bv);
  endfunction

  function automatic logic [7:0] ref4(input logic [3:0] a, input logic [3:0] b);
    int av = {{28{a[3]}}, a};
    int bv = {{28{b[3]}}, b};
    return 8'(av * bv);
  endfunction

  // Full run on the width-8 instance with cycle-exact handshake checks.
  // If inject is set, a second start with other operands arrives mid-run.
  task automatic mul8(input logic [7:0] a, input logic [7:0] b, input string req, input bit inject);
    logic [15:0] exp = ref8(a, b);
    @(negedge clk); s8 = 1'b1; a8 = a; b8 = b;
    @(negedge clk); s8 = 1'b0; a8 = ~a; b8 = b + 8'd3;
    chk({req, " R2 busy after start"}, 32'(busy8), 32'd1);
    for (int i = 1; i <= 8; i++) begin
      if (inject && i == 3) s8 = 1'b1;
      if (inject && i == 5) s8 = 1'b0;
      @(negedge clk);
      if (i < 8) begin
        if (done8 !== 1'b0 || busy8 !== 1'b1) chk({req, " R4 early done"}, {done8, busy8}, 32'b01);
      end
    end
    s8 = 1'b0;
    chk({req, " R4 done on time"}, {done8, busy8}, 32'b10);
    chk({req, " R3 product"}, 32'(p8), 32'(exp));
    @(negedge clk);
    chk({req, " R4 done one clock"}, 32'(done8), 32'd0);
    chk({req, " R7 product held"}, 32'(p8), 32'(exp));
  endtask

  task automatic mul4(input logic [3:0] a, input logic [3:0] b, input string req);
    @(negedge clk); s4 = 1'b1; a4 = a; b4 = b;
    @(negedge clk); s4 = 1'b0;
    for (int i = 1; i <= 4; i++) @(negedge clk);
    if (done4 !== 1'b1) chk({req, " R4 done width4"}, 32'(done4), 32'd1);
    chk(req, 32'(p4), 32'(ref4(a, b)));
  endtask

  task automatic t_reset;
    chk("R1 busy8 reset", 32'(busy8), 32'd0);
    chk("R1 done8 reset", 32'(done8), 32'd0);
    chk("R1 product8 reset", 32'(p8), 32'd0);
    chk("R1 product4 reset", 32'(p4), 32'd0);
  endtask

  task automatic t_worked_example;
    mul4(4'b1011, 4'b1001, "R3 -5*-7");
    chk("R3 -5*-7 literal", 32'(p4), 32'h23);
  endtask

  task automatic t_exhaustive4;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        mul4(4'(a), 4'(b), "R3 R6 exhaustive4");
  endtask

  task automatic t_corners8;
    mul8(8'h80, 8'h80, "R6 min*min", 1'b0);
    chk("R6 min*min literal", 32'(p8), 32'h4000);
    mul8(8'h80, 8'h7f, "R6 min*max", 1'b0);
    mul8(8'h7f, 8'h80, "R6 max*min", 1'b0);
    mul8(8'h80, 8'hff, "R6 min*-1", 1'b0);
    mul8(8'h7f, 8'h7f, "R3 max*max", 1'b0);
    mul8(8'hff, 8'hff, "R9 all-ones multiplier", 1'b0);
    mul8(8'h00, 8'h55, "R3 zero mcand", 1'b0);
    mul8(8'h39, 8'h55, "R9 alternating multiplier", 1'b0);
    mul8(8'hc3, 8'haa, "R9 alternating negative", 1'b0);
  endtask

  task automatic t_random8;
    for (int k = 0; k < 150; k++)
      mul8(8'($urandom), 8'($urandom), "R3 random8", 1'b0);
  endtask

  task automatic t_start_busy;
    mul8(8'hd7, 8'h1b, "R5 start while busy", 1'b1);
    mul8(8'h80, 8'h81, "R5 start while busy min", 1'b1);
  endtask

  initial begin
    #(150000 * 5);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_worked_example();
    t_exhaustive4();
    t_corners8();
    t_start_busy();
    t_random8();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule